// File: doc/BRIEF.md
# Calendar Timekeeping Register Block

This block keeps wall-clock time and a calendar date. A one-cycle tick strobe, normally once per second, advances seconds, minutes and hours. At midnight the tick also advances the day, month and year. Month lengths, February in leap years and the year wrap are all handled inside the block. Software sees two packed 32-bit words on a simple register bus: a time word and a date word. A third word, the control word, holds the busy flags.

A write to the time word or the date word does not take effect at once. The block stages the value and raises a busy flag for that word. A fixed number of clock cycles later it loads the value into the counters and clears the flag. Software polls the flag before it writes the same word again, because a write made while the flag is high is dropped.

Reads return the live counters and are not latched. A tick can therefore fall between a read of the date and a read of the time. Software reads both words twice and repeats until the two snapshots agree.

Top module: `rtc_calendar_core`

## Requirements
- R1: The time word has seconds in bits [5:0], minutes in bits [13:8] and hours in bits [20:16]. All other bits read as zero, also after a write that sets them. After reset the time word reads 0x00000000.
- R2: The date word has the day of month in bits [4:0] and the month (1..12) in bits [11:8]. The year offset from 1970 (0..63) is in bits [21:16] and the leap flag is in bit 22. All other bits read as zero. After reset the date word reads 0x00000101, which is 1 January 1970 with the leap flag clear.
- R3: The date word is at offset 0x10 and the time word at offset 0x14. Offset 0x00 is the control word, with the time busy flag in bit 8 and the date busy flag in bit 7. Every other offset reads zero.
- R4: A write to the time or date word raises that word's busy flag on the write edge. The old value stays readable until the value is loaded, which happens on the edge LOAD_CYCLES clocks after the write edge. The busy flag clears on that same edge.
- R5: A write to a word whose busy flag is high is ignored, and the value that was staged first is the one loaded.
- R6: Each tick advances the seconds. Seconds wrap from 59 to 0 and carry into the minutes, minutes wrap from 59 to 0 and carry into the hours, and hours wrap from 23 to 0 and advance the day. Without a tick the time does not change.
- R7: The day advances to 1, and the month advances by one, after day 30 in April, June, September and November, and after day 31 in the other months except February.
- R8: In February the day rolls over after day 29 when the leap flag is set and after day 28 when it is clear.
- R9: After 31 December the date becomes 1 January of the next year offset, with offset 63 wrapping to 0. The leap flag is then recomputed: it is set exactly when the offset plus 1970 is divisible by 4, which is when the offset modulo 4 equals 2.
- R10: When a time load and a tick fall on the same edge, the loaded time wins and no carry reaches the date.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe that advances time by one second |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |

## Verification
The bench builds the block with LOAD_CYCLES set to 3 instead of the default 2. This shows that the busy window and the load edge follow the parameter: the bench checks the busy flag and the old value on every cycle of that window. The longer window also leaves room to issue a second write while the first is still pending, and to place a tick exactly on the load edge. A vector table starts each case one tick before a rollover and covers every month-length class, both leap states, leap recomputation and the year-63 wrap.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_DATE = 8'h10;
  localparam logic [7:0] OFF_TIME = 8'h14;
  localparam int BIT_TBUSY = 8;
  localparam int BIT_DBUSY = 7;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } hms_t;

  typedef struct packed {
    logic       leap;
    logic [5:0] yr;
    logic [3:0] mo;
    logic [4:0] dy;
  } ymd_t;

  function automatic logic [31:0] pack_hms(hms_t t);
    return {11'd0, t.hr, 2'd0, t.mn, 2'd0, t.sc};
  endfunction

  function automatic hms_t unpack_hms(logic [31:0] w);
    hms_t t;
    t.hr = w[20:16];
    t.mn = w[13:8];
    t.sc = w[5:0];
    return t;
  endfunction

  function automatic logic [31:0] pack_ymd(ymd_t d);
    return {9'd0, d.leap, d.yr, 4'd0, d.mo, 3'd0, d.dy};
  endfunction

  function automatic ymd_t unpack_ymd(logic [31:0] w);
    ymd_t d;
    d.leap = w[22];
    d.yr   = w[21:16];
    d.mo   = w[11:8];
    d.dy   = w[4:0];
    return d;
  endfunction

  function automatic logic [4:0] month_len(logic [3:0] mo, logic leap);
    case (mo)
      4'd2:                     return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
      default:                  return 5'd31;
    endcase
  endfunction

  // offset + 1970 divisible by 4 <=> offset mod 4 == 2
  function automatic logic leap_of(logic [5:0] yr);
    return yr[1:0] == 2'd2;
  endfunction
endpackage

// File: rtl/rtc_defer_load.sv
module rtc_defer_load #(
  parameter int W = 32,
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         busy_o,
  output logic         apply_o,
  output logic [W-1:0] stage_o
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      stage_q <= '0;
    end else if (wr_i && cnt_q == '0) begin
      cnt_q   <= CW'(N);
      stage_q <= wdata_i;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - CW'(1);
    end
  end

  assign busy_o  = cnt_q != '0;
  assign apply_o = cnt_q == CW'(1);
  assign stage_o = stage_q;
endmodule

// File: rtl/rtc_hms_cnt.sv
module rtc_hms_cnt
  import rtc_cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_i,
  input  hms_t load_val_i,
  output hms_t hms_o,
  output logic day_carry_o
);
  hms_t q;
  logic sc_wrap, mn_wrap, hr_wrap;

  assign sc_wrap = q.sc >= 6'd59;
  assign mn_wrap = q.mn >= 6'd59;
  assign hr_wrap = q.hr >= 5'd23;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (load_i) begin
      q <= load_val_i;
    end else if (tick_i) begin
      if (!sc_wrap) begin
        q.sc <= q.sc + 6'd1;
      end else begin
        q.sc <= '0;
        if (!mn_wrap) begin
          q.mn <= q.mn + 6'd1;
        end else begin
          q.mn <= '0;
          q.hr <= hr_wrap ? 5'd0 : q.hr + 5'd1;
        end
      end
    end
  end

  assign hms_o       = q;
  assign day_carry_o = tick_i && !load_i && sc_wrap && mn_wrap && hr_wrap;
endmodule

// File: rtl/rtc_ymd_cnt.sv
module rtc_ymd_cnt
  import rtc_cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic load_i,
  input  ymd_t load_val_i,
  output ymd_t ymd_o
);
  ymd_t q;
  logic end_of_month, end_of_year;
  logic [5:0] yr_next;

  assign end_of_month = q.dy >= month_len(q.mo, q.leap);
  assign end_of_year  = q.mo >= 4'd12;
  assign yr_next      = q.yr + 6'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '{leap: 1'b0, yr: 6'd0, mo: 4'd1, dy: 5'd1};
    end else if (load_i) begin
      q <= load_val_i;
    end else if (inc_i) begin
      if (!end_of_month) begin
        q.dy <= q.dy + 5'd1;
      end else begin
        q.dy <= 5'd1;
        if (!end_of_year) begin
          q.mo <= q.mo + 4'd1;
        end else begin
          q.mo   <= 4'd1;
          q.yr   <= yr_next;
          q.leap <= leap_of(yr_next);
        end
      end
    end
  end

  assign ymd_o = q;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int LOAD_CYCLES = 2,
  parameter int ADDR_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(OFF_DATE);
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(OFF_TIME);

  logic        wr_t, wr_d;
  logic        t_busy, d_busy, t_apply, d_apply, day_carry;
  logic [31:0] t_stage, d_stage, time_word, date_word;
  hms_t        hms;
  ymd_t        ymd;

  assign wr_t = req_i && we_i && addr_i == A_TIME;
  assign wr_d = req_i && we_i && addr_i == A_DATE;

  rtc_defer_load #(.W(32), .N(LOAD_CYCLES)) u_tload (
    .clk_i, .rst_ni, .wr_i(wr_t), .wdata_i(pack_hms(unpack_hms(wdata_i))),
    .busy_o(t_busy), .apply_o(t_apply), .stage_o(t_stage)
  );

  rtc_defer_load #(.W(32), .N(LOAD_CYCLES)) u_dload (
    .clk_i, .rst_ni, .wr_i(wr_d), .wdata_i(pack_ymd(unpack_ymd(wdata_i))),
    .busy_o(d_busy), .apply_o(d_apply), .stage_o(d_stage)
  );

  rtc_hms_cnt u_hms (
    .clk_i, .rst_ni, .tick_i, .load_i(t_apply), .load_val_i(unpack_hms(t_stage)),
    .hms_o(hms), .day_carry_o(day_carry)
  );

  rtc_ymd_cnt u_ymd (
    .clk_i, .rst_ni, .inc_i(day_carry), .load_i(d_apply),
    .load_val_i(unpack_ymd(d_stage)), .ymd_o(ymd)
  );

  assign time_word = pack_hms(hms);
  assign date_word = pack_ymd(ymd);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_TIME: rdata_o = time_word;
      A_DATE: rdata_o = date_word;
      A_CTRL: begin
        rdata_o[BIT_TBUSY] = t_busy;
        rdata_o[BIT_DBUSY] = d_busy;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        wr_t,
  input logic        wr_d,
  input logic        t_busy,
  input logic        d_busy,
  input logic        t_apply,
  input logic        d_apply,
  input logic [31:0] t_stage,
  input logic [31:0] time_word,
  input logic [31:0] date_word
);
  p_tbusy_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_t && !t_busy |=> t_busy);
  p_dbusy_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_d && !d_busy |=> d_busy);
  p_load_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(t_busy) |-> time_word == t_stage);
  p_ignore_busy_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_busy && wr_t |=> $stable(t_stage));
  p_sec_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !t_apply && time_word[5:0] == 6'd59 |=> time_word[5:0] == 6'd0);
  p_hold_no_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !t_apply |=> $stable(time_word));
  p_leap_recalc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    date_word[21:16] != $past(date_word[21:16]) && !$past(d_apply)
    |-> date_word[22] == (date_word[17:16] == 2'd2));
  p_load_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_apply && !d_apply |=> $stable(date_word));
endmodule

bind rtc_calendar_core rtc_calendar_chk u_chk (
  .clk_i, .rst_ni, .tick_i, .wr_t, .wr_d, .t_busy, .d_busy, .t_apply, .d_apply,
  .t_stage, .time_word, .date_word
);

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;
  localparam int CLK_PERIOD = 10;
  localparam int LOAD = 3;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_DATE = 8'h10;
  localparam logic [7:0] A_TIME = 8'h14;
  localparam int NV = 12;

  // time set, date set, ticks, expected time, expected date
  localparam logic [31:0] V_TS [NV] = '{32'h0000003A, 32'h00173B3B, 32'h00173B3B,
    32'h00173B3B, 32'h00173B3B, 32'h00173B3B, 32'h00173B3B, 32'h00173B3B,
    32'h00173B3B, 32'h00173B3B, 32'h000C3B3B, 32'h00000000};
  localparam logic [31:0] V_DS [NV] = '{32'h005E030F, 32'h0000041E, 32'h0000011F,
    32'h0042021C, 32'h0003021C, 32'h0042021D, 32'h00010C1F, 32'h003F0C1F,
    32'h00420C1F, 32'h0000071E, 32'h00000101, 32'h0000091E};
  localparam int          V_N  [NV] = '{3, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0};
  localparam logic [31:0] V_ET [NV] = '{32'h00000101, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h000D0000, 32'h0};
  localparam logic [31:0] V_ED [NV] = '{32'h005E030F, 32'h00000501, 32'h00000201,
    32'h0042021D, 32'h00030301, 32'h00420301, 32'h00420101, 32'h00000101,
    32'h00030101, 32'h0000071F, 32'h00000101, 32'h0000091E};
  // tags: 0 R6 carry, 1 R7 30-day, 2 R7 31-day, 3 R8 leap, 4 R8 non-leap,
  // 5 R8 leap end, 6 R9 leap set, 7 R9 wrap, 8 R9 leap clear, 9 R7 no roll,
  // 10 R6 hour carry, 11 R6 no tick

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rtc_calendar_core #(.LOAD_CYCLES(LOAD), .ADDR_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < LOAD + 1; i++) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(A_TIME, d); chk("R1 reset time", d, 32'h0);
    rd(A_DATE, d); chk("R2 reset date", d, 32'h00000101);
    rd(A_CTRL, d); chk("R3 reset ctrl", d, 32'h0);
    rd(8'h20, d);  chk("R3 unmapped offset", d, 32'h0);

    // R4 time busy window
    wr(A_TIME, 32'h000A0B0C);
    for (int i = 1; i < LOAD; i++) begin
      rd(A_CTRL, d); chk("R4 time busy high", d, 32'h00000100);
      rd(A_TIME, d); chk("R4 old time held", d, 32'h0);
      @(negedge clk);
    end
    rd(A_CTRL, d); chk("R4 time busy last", d, 32'h00000100);
    @(negedge clk);
    rd(A_CTRL, d); chk("R4 time busy cleared", d, 32'h0);
    rd(A_TIME, d); chk("R4 time loaded", d, 32'h000A0B0C);

    // R4 date busy
    wr(A_DATE, 32'h0005060B);
    rd(A_CTRL, d); chk("R4 date busy high", d, 32'h00000080);
    rd(A_DATE, d); chk("R4 old date held", d, 32'h00000101);
    settle();
    rd(A_CTRL, d); chk("R4 date busy cleared", d, 32'h0);
    rd(A_DATE, d); chk("R4 date loaded", d, 32'h0005060B);

    // R1/R2 masking of unused bits
    wr(A_TIME, 32'hFFFFFFFF); wr(A_DATE, 32'hFFFFFFFF); settle();
    rd(A_TIME, d); chk("R1 unused bits zero", d, 32'h001F3F3F);
    rd(A_DATE, d); chk("R2 unused bits zero", d, 32'h007F0F1F);

    // R5 second write while busy dropped
    wr(A_TIME, 32'h00010203);
    wr(A_TIME, 32'h00040506);
    settle();
    rd(A_TIME, d); chk("R5 busy write ignored", d, 32'h00010203);

    // vector table
    for (int v = 0; v < NV; v++) begin
      wr(A_TIME, V_TS[v]);
      wr(A_DATE, V_DS[v]);
      settle();
      for (int k = 0; k < V_N[v]; k++) pulse();
      rd(A_TIME, d); chk($sformatf("R6 R7 R8 R9 vec%0d time", v), d, V_ET[v]);
      rd(A_DATE, d); chk($sformatf("R6 R7 R8 R9 vec%0d date", v), d, V_ED[v]);
    end

    // R6 no change without tick over many cycles
    wr(A_TIME, 32'h00020304); settle();
    repeat (20) @(negedge clk);
    rd(A_TIME, d); chk("R6 hold without tick", d, 32'h00020304);

    // R10 load and tick on the same edge
    wr(A_TIME, 32'h00173B3B); wr(A_DATE, 32'h00000105); settle();
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = A_TIME; wdata = 32'h00050000;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    for (int i = 1; i < LOAD; i++) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    rd(A_TIME, d); chk("R10 loaded time wins", d, 32'h00050000);
    rd(A_DATE, d); chk("R10 no date carry", d, 32'h00000105);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule